// File: doc/BRIEF.md
# Device Interrupt Queue Trap Controller

This block holds the two pointers of a device interrupt queue in a core: a head pointer that software advances as it consumes entries, and a tail pointer that the hypervisor advances as it appends them. Whenever the two differ, the queue holds unserviced entries, and the block requests a device-queue trap from the core. The entries themselves live in memory outside this block.

Software reaches the pointers through a register-access port. Each access carries a read or write strobe, a register select and the privilege level of the access. The block checks every access against fixed privilege rules. A forbidden write leaves the register unchanged and raises an access exception. Trap delivery is gated by the core's current mode and by the global interrupt-enable bit. Once the core has taken the trap, the request stays masked until the handler returns, so one pending condition produces one trap per handler run.

Top module: `dq_trap_ctl`

## Requirements
- R1: Out of reset, both pointers read as zero, and trap_req, acc_exc and acc_rvalid are low.
- R2: The trap condition is a level. When head differs from tail and delivery is allowed, trap_req is high one cycle after the register update. It returns low one cycle after the two pointers become equal.
- R3: A write with acc_sel=0 (head) at privilege 2'b01 (supervisor), 2'b10 or 2'b11 (hypervisor) loads acc_wdata into head and raises no exception.
- R4: A write with acc_sel=1 (tail) at hypervisor privilege loads tail with no exception. The same write at supervisor privilege leaves tail unchanged and pulses acc_exc in the next cycle.
- R5: Any read or write at privilege 2'b00 (user) pulses acc_exc in the next cycle, and a user write changes neither pointer.
- R6: A read at any privilege sets acc_rvalid in the next cycle, with acc_rdata holding the selected pointer's value at the time of the read. The read has no side effect on either pointer or on trap_req.
- R7: While core_hyp is high, trap_req stays low. When core_hyp falls with the condition still true, trap_req rises one cycle later.
- R8: While irq_en is low, trap_req stays low.
- R9: trap_tt carries 0x7D and acc_exc_tt carries 0x14.
- R10: A trap_taken pulse drops trap_req in the next cycle and keeps it low until a trap_done pulse. trap_req may rise again from the cycle after the one following trap_done.
- R11: A write that copies the tail value into head clears the request: after that handler run, no trap is raised until the pointers differ again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Register read strobe |
| acc_wr | input | 1 | Register write strobe |
| acc_sel | input | 1 | 0 = head pointer, 1 = tail pointer |
| acc_priv | input | 2 | Access privilege: 00 user, 01 supervisor, 1x hypervisor |
| acc_wdata | input | PTR_W | Write data |
| acc_rdata | output | PTR_W | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read data valid, one cycle after acc_rd |
| acc_exc | output | 1 | Access exception pulse |
| acc_exc_tt | output | TT_W | Access exception trap type (0x14) |
| core_hyp | input | 1 | Core is running in hypervisor mode |
| irq_en | input | 1 | Global interrupt enable |
| trap_taken | input | 1 | Core has taken the queue trap |
| trap_done | input | 1 | Queue trap handler has returned |
| trap_req | output | 1 | Queue trap request |
| trap_tt | output | TT_W | Queue trap type (0x7D) |

## Verification
The bench builds the block with PTR_W=8, so the pointer space is small enough to sweep. With that width it walks every head value against a fixed tail and compares trap_req with the inequality it computes itself. It also crosses all four privilege codes with both registers for writes and reads. The gating inputs irq_en and core_hyp are swept in all combinations. Then the full handler round trip is run: take, mask, clear by copying tail into head, and return.

// File: rtl/dqt_pkg.sv
package dqt_pkg;
  typedef enum logic [1:0] {
    PL_USER = 2'b00,
    PL_SUP  = 2'b01,
    PL_HYP  = 2'b10,
    PL_HYPX = 2'b11
  } priv_e;

  localparam logic SEL_HEAD = 1'b0;
  localparam logic SEL_TAIL = 1'b1;

  localparam int unsigned TT_W        = 9;
  localparam logic [8:0]  TT_QUEUE    = 9'h07D;
  localparam logic [8:0]  TT_BAD_ASPC = 9'h014;
endpackage

// File: rtl/dqt_access_chk.sv
module dqt_access_chk
  import dqt_pkg::*;
(
  input  logic       rd,
  input  logic       wr,
  input  logic       sel,
  input  logic [1:0] priv,
  output logic       wr_head,
  output logic       wr_tail,
  output logic       violation
);
  logic is_user;
  logic is_hyp;

  always_comb begin
    is_user   = (priv == PL_USER);
    is_hyp    = priv[1];
    wr_head   = wr && (sel == SEL_HEAD) && !is_user;
    wr_tail   = wr && (sel == SEL_TAIL) && is_hyp;
    violation = ((rd || wr) && is_user) ||
                (wr && (sel == SEL_TAIL) && !is_hyp);
  end
endmodule

// File: rtl/dqt_ptr_regs.sv
module dqt_ptr_regs #(
  parameter int unsigned PTR_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_head,
  input  logic             wr_tail,
  input  logic [PTR_W-1:0] wdata,
  input  logic             rd,
  input  logic             sel,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [PTR_W-1:0] rdata,
  output logic             rvalid
);
  logic [PTR_W-1:0] ptr_q [2];

  for (genvar i = 0; i < 2; i++) begin : g_ptr
    logic we;
    assign we = (i == 0) ? wr_head : wr_tail;
    always_ff @(posedge clk) begin
      if (rst)     ptr_q[i] <= '0;
      else if (we) ptr_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= ptr_q[sel];
    end
  end

  assign head = ptr_q[0];
  assign tail = ptr_q[1];
endmodule

// File: rtl/dqt_trap_gate.sv
module dqt_trap_gate (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic core_hyp,
  input  logic irq_en,
  input  logic trap_taken,
  input  logic trap_done,
  output logic trap_req
);
  logic in_handler_q;
  logic req_d;

  always_comb begin
    req_d = pending && irq_en && !core_hyp && !in_handler_q && !trap_taken;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_handler_q <= 1'b0;
      trap_req     <= 1'b0;
    end else begin
      if (trap_taken)     in_handler_q <= 1'b1;
      else if (trap_done) in_handler_q <= 1'b0;
      trap_req <= req_d;
    end
  end
endmodule

// File: rtl/dq_trap_ctl.sv
module dq_trap_ctl
  import dqt_pkg::*;
#(
  parameter int unsigned PTR_W = 64,
  parameter int unsigned TT_W  = dqt_pkg::TT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic             acc_sel,
  input  logic [1:0]       acc_priv,
  input  logic [PTR_W-1:0] acc_wdata,
  output logic [PTR_W-1:0] acc_rdata,
  output logic             acc_rvalid,
  output logic             acc_exc,
  output logic [TT_W-1:0]  acc_exc_tt,
  input  logic             core_hyp,
  input  logic             irq_en,
  input  logic             trap_taken,
  input  logic             trap_done,
  output logic             trap_req,
  output logic [TT_W-1:0]  trap_tt
);
  logic             wr_head, wr_tail, violation;
  logic [PTR_W-1:0] head_q, tail_q;
  logic             pending;

  dqt_access_chk u_chk_acc (
    .rd(acc_rd), .wr(acc_wr), .sel(acc_sel), .priv(acc_priv),
    .wr_head(wr_head), .wr_tail(wr_tail), .violation(violation)
  );

  dqt_ptr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_head(wr_head), .wr_tail(wr_tail),
    .wdata(acc_wdata), .rd(acc_rd), .sel(acc_sel),
    .head(head_q), .tail(tail_q), .rdata(acc_rdata), .rvalid(acc_rvalid)
  );

  assign pending = (head_q != tail_q);

  dqt_trap_gate u_gate (
    .clk(clk), .rst(rst), .pending(pending), .core_hyp(core_hyp),
    .irq_en(irq_en), .trap_taken(trap_taken), .trap_done(trap_done),
    .trap_req(trap_req)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_exc <= 1'b0;
    else     acc_exc <= violation;
  end

  assign acc_exc_tt = TT_W'(TT_BAD_ASPC);
  assign trap_tt    = TT_W'(TT_QUEUE);
endmodule

// File: rtl/dq_trap_ctl_chk.sv
module dq_trap_ctl_chk #(
  parameter int unsigned PTR_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_rd,
  input logic             acc_wr,
  input logic             acc_sel,
  input logic [1:0]       acc_priv,
  input logic [PTR_W-1:0] acc_wdata,
  input logic             acc_rvalid,
  input logic             acc_exc,
  input logic             core_hyp,
  input logic             irq_en,
  input logic             trap_taken,
  input logic             trap_req,
  input logic [PTR_W-1:0] head,
  input logic [PTR_W-1:0] tail
);
  a_r2_level_source: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(head != tail));

  a_r3_head_write: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && !acc_sel && acc_priv != 2'b00) |=> (head == $past(acc_wdata)) && !acc_exc);

  a_r4_tail_guard: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && acc_sel && acc_priv == 2'b01) |=> acc_exc && $stable(tail));

  a_r5_user_exc: assert property (@(posedge clk) disable iff (rst)
    ((acc_wr || acc_rd) && acc_priv == 2'b00) |=> acc_exc && $stable(head) && $stable(tail));

  a_r6_read_valid: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> acc_rvalid);

  a_r7_hyp_hold: assert property (@(posedge clk) disable iff (rst)
    core_hyp |=> !trap_req);

  a_r8_ie_gate: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !trap_req);

  a_r10_taken_mask: assert property (@(posedge clk) disable iff (rst)
    trap_taken |=> !trap_req);
endmodule

bind dq_trap_ctl dq_trap_ctl_chk #(.PTR_W(PTR_W)) u_trap_chk (
  .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_sel(acc_sel),
  .acc_priv(acc_priv), .acc_wdata(acc_wdata), .acc_rvalid(acc_rvalid),
  .acc_exc(acc_exc), .core_hyp(core_hyp), .irq_en(irq_en),
  .trap_taken(trap_taken), .trap_req(trap_req), .head(head_q), .tail(tail_q)
);

// File: tb/tb_dq_trap_ctl.sv
module tb_dq_trap_ctl;
  localparam int W  = 8;
  localparam int TW = 9;

  logic          clk = 1'b0;
  logic          rst;
  logic          acc_rd, acc_wr, acc_sel;
  logic [1:0]    acc_priv;
  logic [W-1:0]  acc_wdata, acc_rdata;
  logic          acc_rvalid, acc_exc;
  logic [TW-1:0] acc_exc_tt, trap_tt;
  logic          core_hyp, irq_en, trap_taken, trap_done, trap_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dq_trap_ctl #(.PTR_W(W), .TT_W(TW)) dut (
    .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_sel(acc_sel),
    .acc_priv(acc_priv), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_rvalid(acc_rvalid), .acc_exc(acc_exc), .acc_exc_tt(acc_exc_tt),
    .core_hyp(core_hyp), .irq_en(irq_en), .trap_taken(trap_taken),
    .trap_done(trap_done), .trap_req(trap_req), .trap_tt(trap_tt)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [1:0] pr, input logic [W-1:0] d,
                        output logic exc);
    @(negedge clk);
    acc_wr = 1'b1; acc_sel = sel; acc_priv = pr; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
    exc = acc_exc;
  endtask

  task automatic rd_reg(input logic sel, input logic [1:0] pr,
                        output logic [W-1:0] d, output logic exc, output logic vld);
    @(negedge clk);
    acc_rd = 1'b1; acc_sel = sel; acc_priv = pr;
    @(negedge clk);
    acc_rd = 1'b0;
    d = acc_rdata; exc = acc_exc; vld = acc_rvalid;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic          e, v;
    logic [W-1:0]  d, hv, tv;
    rst = 1'b1; acc_rd = 0; acc_wr = 0; acc_sel = 0; acc_priv = 2'b10; acc_wdata = '0;
    core_hyp = 0; irq_en = 0; trap_taken = 0; trap_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(trap_req == 0 && acc_exc == 0 && acc_rvalid == 0, "R1 outputs", {trap_req, acc_exc, acc_rvalid}, 0);
    rd_reg(0, 2'b10, d, e, v); chk(d == 0, "R1 head", d, 0);
    rd_reg(1, 2'b10, d, e, v); chk(d == 0, "R1 tail", d, 0);
    // R9 trap type codes
    chk(trap_tt == 9'h07D, "R9 trap_tt", trap_tt, 9'h07D);
    chk(acc_exc_tt == 9'h014, "R9 exc_tt", acc_exc_tt, 9'h014);

    // R3 R4 R5 R6: privilege x register write sweep, read back at hypervisor
    hv = 0; tv = 0;
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 2; s++) begin
        logic [W-1:0] val;
        bit allowed;
        val = W'(8'h11 * (p * 2 + s + 1));
        allowed = (s == 0) ? (p != 0) : (p >= 2);
        wr_reg(s[0], p[1:0], val, e);
        chk(e == !allowed, s == 0 ? "R3 head write exc" : (p == 0 ? "R5 user write exc" : "R4 tail write exc"), e, !allowed);
        if (allowed) begin
          if (s == 0) hv = val; else tv = val;
        end
        rd_reg(0, 2'b10, d, e, v); chk(d == hv && v, "R3 head readback", d, hv);
        rd_reg(1, 2'b10, d, e, v); chk(d == tv && v, "R4 tail readback", d, tv);
      end
    end

    // R5 R6: reads at every privilege; user raises exception but still returns data
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 2; s++) begin
        rd_reg(s[0], p[1:0], d, e, v);
        chk(v == 1, "R6 rvalid", v, 1);
        chk(d == (s == 0 ? hv : tv), "R6 read data", d, s == 0 ? hv : tv);
        chk(e == (p == 0), "R5 user read exc", e, p == 0);
      end
    end
    rd_reg(0, 2'b10, d, e, v); chk(d == hv, "R6 no side effect head", d, hv);

    // R2: level sweep of every head value against a fixed tail
    irq_en = 1; core_hyp = 0;
    wr_reg(1, 2'b10, 8'h5A, e); tv = 8'h5A;
    for (int h = 0; h < (1 << W); h++) begin
      wr_reg(0, 2'b01, W'(h), e);
      @(negedge clk);
      chk(trap_req == (W'(h) != tv), "R2 level", trap_req, W'(h) != tv);
    end
    // head now 0xFF, tail 0x5A: pending

    // R7 R8: gating sweep
    for (int g = 0; g < 4; g++) begin
      @(negedge clk);
      irq_en = g[0]; core_hyp = g[1];
      @(negedge clk);
      chk(trap_req == (g[0] && !g[1]), g[1] ? "R7 hyp hold" : "R8 ie gate", trap_req, g[0] && !g[1]);
    end
    // hold in hyp, then return to supervisor
    irq_en = 1; core_hyp = 1;
    repeat (3) @(negedge clk);
    chk(trap_req == 0, "R7 hyp held", trap_req, 0);
    core_hyp = 0;
    @(negedge clk);
    chk(trap_req == 1, "R7 return delivers", trap_req, 1);

    // R10: take, stay masked, return with condition still true
    trap_taken = 1; @(negedge clk); trap_taken = 0;
    chk(trap_req == 0, "R10 masked after take", trap_req, 0);
    repeat (4) @(negedge clk);
    chk(trap_req == 0, "R10 masked in handler", trap_req, 0);
    trap_done = 1; @(negedge clk); trap_done = 0;
    @(negedge clk);
    chk(trap_req == 1, "R10 re-raise after done", trap_req, 1);

    // R11: handler clears by copying tail into head
    trap_taken = 1; @(negedge clk); trap_taken = 0;
    rd_reg(1, 2'b01, d, e, v);
    wr_reg(0, 2'b01, d, e);
    trap_done = 1; @(negedge clk); trap_done = 0;
    repeat (4) @(negedge clk);
    chk(trap_req == 0, "R11 cleared", trap_req, 0);
    wr_reg(1, 2'b10, d + 8'd1, e);
    @(negedge clk);
    chk(trap_req == 1, "R11 new entry", trap_req, 1);
    wr_reg(1, 2'b01, d, e);
    @(negedge clk);
    chk(e == 1 && trap_req == 1, "R4 supervisor tail write blocked", {e, trap_req}, 2'b11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule